// File: doc/BRIEF.md
# Translation Cache with Global Entry Retention

This block is a small, fully associative cache of address translations that sits between a core's linear-address path and its page walker. Each of its entries maps one linear page to a physical frame and keeps the permission bits (writable, user-accessible), the dirty bit, the global bit, and two cache-policy bits (uncached, write-through). A lookup is presented for one cycle and answered one cycle later with a hit flag, the composed physical address and the entry's attributes. On a miss the walker fetches the mapping and hands it back through the refill port.

Entries may describe an ordinary 4 KB page or a large page of 4 MB or 2 MB. Two kinds of invalidation keep the cache coherent with the page tables. A page-directory-base reload drops the entries that are not global, or all entries when global retention is disabled. An address invalidate drops the entries that cover one linear page. When both an invalidate and a refill arrive in the same cycle, the invalidate wins.

Top module: `xc_tlb`

## Requirements
- R1: A lookup with `lk_valid` high in cycle k produces `rsp_valid` high in cycle k+1 only, and `rsp_hit` is never high without `rsp_valid`.
- R2: A lookup that hits a 4 KB entry (size code 0) returns `rsp_pa = {pfn, va[11:0]}` with that entry's rw, us, pcd and pwt bits. A lookup whose page number is not held reports a miss.
- R3: A 4 MB entry (size code 1) matches on va[31:22] and returns `{pfn[23:10], va[21:0]}`. A 2 MB entry (size code 2) matches on va[31:21] and returns `{pfn[23:9], va[20:0]}`.
- R4: A write lookup that hits an entry whose dirty bit is clear reports a miss. A read to the same entry hits, and a write to an entry with dirty set hits.
- R5: `cr3_load` with `pge_en` low removes every entry. A refill in that same cycle is dropped.
- R6: `cr3_load` with `pge_en` high removes only the entries with the global bit clear. A refill in that cycle is kept only if its global bit is set.
- R7: An invalidate removes every entry covering `inv_vpn`, judged at that entry's own page size, and leaves the other entries intact.
- R8: When an invalidate and a refill share a cycle, the invalidate is applied. The refill is dropped if its page covers the invalidated page and is written otherwise.
- R9: A refill goes to the lowest-numbered empty slot. When all 8 slots are full, it evicts the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances only on such an eviction.
- R10: A refill whose page is already held overwrites that entry in place and evicts nothing.
- R11: Reset empties the cache and clears `rsp_valid`, so the first lookup after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup linear address |
| lk_write | input | 1 | Lookup is for a write |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Translation usable |
| rsp_pa | output | 36 | Physical address |
| rsp_rw | output | 1 | Entry writable |
| rsp_us | output | 1 | Entry user-accessible |
| rsp_pcd | output | 1 | Caching disabled for the page |
| rsp_pwt | output | 1 | Page is write-through (0 write-back) |
| fill_valid | input | 1 | Refill from the walker |
| fill_vpn | input | 20 | Linear page number va[31:12] of the refill |
| fill_pfn | input | 24 | Physical frame number |
| fill_size | input | 2 | 0 = 4 KB, 1 = 4 MB, 2 = 2 MB |
| fill_g | input | 1 | Global bit |
| fill_rw | input | 1 | Writable bit |
| fill_us | input | 1 | User bit |
| fill_d | input | 1 | Dirty bit |
| fill_pcd | input | 1 | Cache-disable bit |
| fill_pwt | input | 1 | Write-through bit |
| cr3_load | input | 1 | Page-directory base reload |
| pge_en | input | 1 | Global retention enable |
| inv_valid | input | 1 | Single-page invalidate |
| inv_vpn | input | 20 | Linear page number to invalidate |

## Verification
Both an invalidate and a refill, or a base reload and a refill, can land in the same clock. The bench provokes this by driving a refill together with an invalidate of an address inside the refilled page, and then again with an unrelated invalidate address. It also drives a global refill together with a reload that retains global entries. Each case is judged by a lookup issued afterwards. That lookup must miss where the refill was to be discarded and must return the refilled frame where it was to be kept.

// File: rtl/xc_pkg.sv
// Shared page-size encoding, attribute record and shift helper for the
// translation cache. Assumes 4 KB base pages (12 offset bits).
package xc_pkg;
    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_4M = 2'd1,
        PG_2M = 2'd2
    } pg_size_e;

    typedef struct packed {
        logic rw;
        logic us;
        logic d;
        logic pcd;
        logic pwt;
        logic g;
    } xc_attr_t;

    localparam logic [4:0] SH_4K = 5'd12;
    localparam logic [4:0] SH_4M = 5'd22;
    localparam logic [4:0] SH_2M = 5'd21;

    // Number of in-page offset bits for a page size code.
    function automatic logic [4:0] pg_shift(pg_size_e s);
        case (s)
            PG_4M:   return SH_4M;
            PG_2M:   return SH_2M;
            default: return SH_4K;
        endcase
    endfunction
endpackage

// File: rtl/xc_match.sv
// Page comparator: tells whether a stored page (tag plus size) covers a
// given linear page number. Assumes the tag holds va[VA_W-1:12].
module xc_match
    import xc_pkg::*;
#(
    parameter int VA_W = 32,
    localparam int TAG_W = VA_W - 12
) (
    input  logic             vld,
    input  logic [TAG_W-1:0] tag,
    input  pg_size_e         size,
    input  logic [TAG_W-1:0] vpn,
    output logic             hit
);
    logic [TAG_W-1:0] diff;
    logic [TAG_W-1:0] keep;

    // Compare only the page-number bits above the page's own offset.
    always_comb begin
        diff = tag ^ vpn;
        keep = {TAG_W{1'b1}} << (pg_shift(size) - SH_4K);
        hit  = vld && ((diff & keep) == '0);
    end
endmodule

// File: rtl/xc_victim.sv
// Refill slot chooser: lowest empty slot, else a round-robin pointer that
// advances only when the caller reports an eviction through adv.
module xc_victim #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  vld,
    input  logic          adv,
    output logic [IW-1:0] victim,
    output logic          full
);
    logic [IW-1:0] ptr_q;

    // Find the lowest-numbered empty slot, defaulting to the pointer.
    always_comb begin
        victim = ptr_q;
        full   = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                victim = IW'(i);
                full   = 1'b0;
            end
        end
    end

    // Step the round-robin pointer on each eviction, wrapping at N.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (adv)
            ptr_q <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
endmodule

// File: rtl/xc_tlb.sv
// Fully associative translation cache, N entries, registered one-cycle
// lookup. Refill, base reload and page invalidate update the array at the
// clock edge. A lookup sees the array as it stood before that edge.
// Assumes PA_W >= VA_W and that the walker only refills after a miss.
module xc_tlb
    import xc_pkg::*;
#(
    parameter int N    = 8,
    parameter int VA_W = 32,
    parameter int PA_W = 36,
    localparam int TAG_W = VA_W - 12,
    localparam int PFN_W = PA_W - 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             lk_write,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_rw,
    output logic             rsp_us,
    output logic             rsp_pcd,
    output logic             rsp_pwt,
    input  logic             fill_valid,
    input  logic [TAG_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [1:0]       fill_size,
    input  logic             fill_g,
    input  logic             fill_rw,
    input  logic             fill_us,
    input  logic             fill_d,
    input  logic             fill_pcd,
    input  logic             fill_pwt,
    input  logic             cr3_load,
    input  logic             pge_en,
    input  logic             inv_valid,
    input  logic [TAG_W-1:0] inv_vpn
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     vld_q;
    logic [TAG_W-1:0] tag_q  [N];
    pg_size_e         size_q [N];
    logic [PFN_W-1:0] pfn_q  [N];
    xc_attr_t         attr_q [N];

    logic [N-1:0]  glb_vec;
    logic [N-1:0]  lk_hv;
    logic [N-1:0]  inv_hv;
    logic [N-1:0]  fill_hv;
    logic          lk_any;
    logic [IW-1:0] lk_sel;
    logic          fill_any;
    logic [IW-1:0] fill_sel;
    logic          fill_covers_inv;
    logic          fill_drop;
    logic          fill_do;
    logic [IW-1:0] fill_tgt;
    logic [IW-1:0] victim;
    logic          full;
    logic          adv;
    pg_size_e      fill_sz;
    xc_attr_t      fill_attr;

    assign fill_sz   = pg_size_e'(fill_size);
    assign fill_attr = '{rw: fill_rw, us: fill_us, d: fill_d,
                         pcd: fill_pcd, pwt: fill_pwt, g: fill_g};

    // Join the frame bits above the page offset with the offset bits of va.
    function automatic logic [PA_W-1:0] join_pa(logic [PFN_W-1:0] pfn,
                                                pg_size_e sz,
                                                logic [VA_W-1:0] va);
        logic [PA_W-1:0] low;
        low = ~({PA_W{1'b1}} << pg_shift(sz));
        return ({pfn, 12'h000} & ~low) | (PA_W'(va) & low);
    endfunction

    // Per-entry comparators for lookup, invalidate and refill duplicate check.
    for (genvar i = 0; i < N; i++) begin : g_ent
        assign glb_vec[i] = attr_q[i].g;
        xc_match #(.VA_W(VA_W)) u_lk (
            .vld(vld_q[i]), .tag(tag_q[i]), .size(size_q[i]),
            .vpn(lk_va[VA_W-1:12]), .hit(lk_hv[i]));
        xc_match #(.VA_W(VA_W)) u_inv (
            .vld(vld_q[i]), .tag(tag_q[i]), .size(size_q[i]),
            .vpn(inv_vpn), .hit(inv_hv[i]));
        xc_match #(.VA_W(VA_W)) u_fill (
            .vld(vld_q[i]), .tag(tag_q[i]), .size(size_q[i]),
            .vpn(fill_vpn), .hit(fill_hv[i]));
    end

    // Does the incoming refill page contain the page being invalidated?
    xc_match #(.VA_W(VA_W)) u_collide (
        .vld(1'b1), .tag(fill_vpn), .size(fill_sz),
        .vpn(inv_vpn), .hit(fill_covers_inv));

    // Lowest-index hit selection for lookup and for in-place refill.
    always_comb begin
        lk_any   = 1'b0;
        lk_sel   = '0;
        fill_any = 1'b0;
        fill_sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (lk_hv[i]) begin
                lk_any = 1'b1;
                lk_sel = IW'(i);
            end
            if (fill_hv[i]) begin
                fill_any = 1'b1;
                fill_sel = IW'(i);
            end
        end
    end

    // Refill admission: invalidate and reload take priority over the refill.
    always_comb begin
        fill_drop = (inv_valid && fill_covers_inv) ||
                    (cr3_load && !(fill_g && pge_en));
        fill_do   = fill_valid && !fill_drop;
        fill_tgt  = fill_any ? fill_sel : victim;
        adv       = fill_do && !fill_any && full;
    end

    xc_victim #(.N(N)) u_victim (
        .clk(clk), .rst_n(rst_n), .vld(vld_q), .adv(adv),
        .victim(victim), .full(full));

    // Valid bits: clear on reload or invalidate, then set by an admitted refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (cr3_load && !(attr_q[i].g && pge_en))
                    vld_q[i] <= 1'b0;
                if (inv_valid && inv_hv[i])
                    vld_q[i] <= 1'b0;
            end
            if (fill_do)
                vld_q[fill_tgt] <= 1'b1;
        end
    end

    // Entry payload: written by an admitted refill, no reset needed.
    always_ff @(posedge clk) begin
        if (fill_do) begin
            tag_q[fill_tgt]  <= fill_vpn;
            size_q[fill_tgt] <= fill_sz;
            pfn_q[fill_tgt]  <= fill_pfn;
            attr_q[fill_tgt] <= fill_attr;
        end
    end

    // Response strobe and hit: a clean entry cannot satisfy a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_any && !(lk_write && !attr_q[lk_sel].d);
        end
    end

    // Response payload taken from the selected entry.
    always_ff @(posedge clk) begin
        rsp_pa  <= join_pa(pfn_q[lk_sel], size_q[lk_sel], lk_va);
        rsp_rw  <= attr_q[lk_sel].rw;
        rsp_us  <= attr_q[lk_sel].us;
        rsp_pcd <= attr_q[lk_sel].pcd;
        rsp_pwt <= attr_q[lk_sel].pwt;
    end
endmodule

// File: rtl/xc_tlb_chk.sv
// Property checker for xc_tlb, attached by bind. It watches the control
// ports and the valid and global vectors of the entry array.
module xc_tlb_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lk_valid,
    input logic         rsp_valid,
    input logic         rsp_hit,
    input logic         fill_valid,
    input logic         cr3_load,
    input logic         pge_en,
    input logic         inv_valid,
    input logic [N-1:0] vld,
    input logic [N-1:0] glb
);
    a_r1_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r1_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    a_r1_hit_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
    a_r5_full_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (cr3_load && !pge_en) |=> (vld == '0));
    a_r6_only_global_left: assert property (@(posedge clk) disable iff (!rst_n)
        (cr3_load && pge_en) |=> ((vld & ~glb) == '0));
    a_r7_inv_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !fill_valid && !cr3_load) |=>
        ($countones(vld) <= $past($countones(vld))));
    a_r9_fill_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !inv_valid && !cr3_load) |=>
        ($countones(vld) >= $past($countones(vld))));
    a_r11_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (vld == '0 && !rsp_valid));
endmodule

bind xc_tlb xc_tlb_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .fill_valid(fill_valid), .cr3_load(cr3_load),
    .pge_en(pge_en), .inv_valid(inv_valid), .vld(vld_q), .glb(glb_vec));

// File: tb/xc_tlb_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: lookups push expectations, a monitor compares answers.
module xc_tlb_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_va = '0;
    logic        rsp_valid, rsp_hit, rsp_rw, rsp_us, rsp_pcd, rsp_pwt;
    logic [35:0] rsp_pa;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [23:0] fill_pfn = '0;
    logic [1:0]  fill_size = '0;
    logic        fill_g = 0, fill_rw = 0, fill_us = 0, fill_d = 0, fill_pcd = 0, fill_pwt = 0;
    logic        cr3_load = 1'b0, pge_en = 1'b0, inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic        q_hit  [$];
    logic [35:0] q_pa   [$];
    logic [3:0]  q_attr [$];
    string       q_req  [$];

    always #10 clk = ~clk;

    xc_tlb u_dut (.*);

    // Expected physical address per R2/R3.
    function automatic logic [35:0] epa(logic [23:0] pfn, int sz, logic [31:0] va);
        if (sz == 1) return {pfn[23:10], va[21:0]};
        if (sz == 2) return {pfn[23:9], va[20:0]};
        return {pfn, va[11:0]};
    endfunction

    task automatic tick();
        @(posedge clk); #1;
        lk_valid = 0; fill_valid = 0; inv_valid = 0; cr3_load = 0;
    endtask

    task automatic put_fill(logic [31:0] va, logic [23:0] pfn, int sz,
                            logic g, logic d, logic [3:0] at);
        fill_valid = 1; fill_vpn = va[31:12]; fill_pfn = pfn; fill_size = 2'(sz);
        fill_g = g; fill_d = d;
        {fill_rw, fill_us, fill_pcd, fill_pwt} = at;
    endtask

    task automatic fill(logic [31:0] va, logic [23:0] pfn, int sz,
                        logic g, logic d, logic [3:0] at);
        put_fill(va, pfn, sz, g, d, at);
        tick();
    endtask

    task automatic inv(logic [31:0] va);
        inv_valid = 1; inv_vpn = va[31:12];
        tick();
    endtask

    task automatic reload(logic pge);
        cr3_load = 1; pge_en = pge;
        tick();
    endtask

    // Lookup with expectation; attr order {rw, us, pcd, pwt}.
    task automatic look(logic [31:0] va, logic wr, logic eh, logic [35:0] pa,
                        logic [3:0] at, string req);
        lk_valid = 1; lk_va = va; lk_write = wr;
        q_hit.push_back(eh); q_pa.push_back(pa); q_attr.push_back(at); q_req.push_back(req);
        tick();
    endtask

    task automatic miss(logic [31:0] va, logic wr, string req);
        look(va, wr, 1'b0, '0, '0, req);
    endtask

    // Monitor: pop one expectation per answer and compare away from the edge.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_chk++;
            if (q_hit.size() == 0) begin
                n_bad++;
                $display("FAIL R1: unexpected answer act=1 exp=0");
            end else begin
                logic eh; logic [35:0] pa; logic [3:0] at; string rq;
                eh = q_hit.pop_front(); pa = q_pa.pop_front();
                at = q_attr.pop_front(); rq = q_req.pop_front();
                if (rsp_hit !== eh) begin
                    n_bad++;
                    $display("FAIL %s: hit act=%b exp=%b", rq, rsp_hit, eh);
                end else if (eh && (rsp_pa !== pa ||
                         {rsp_rw, rsp_us, rsp_pcd, rsp_pwt} !== at)) begin
                    n_bad++;
                    $display("FAIL %s: pa/attr act=%h/%b exp=%h/%b", rq, rsp_pa,
                             {rsp_rw, rsp_us, rsp_pcd, rsp_pwt}, pa, at);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] pg [12];
        for (int i = 0; i < 12; i++) pg[i] = 32'h4000_0000 | (32'(i) << 12);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R11: rsp_valid act=%b exp=0", rsp_valid);
        end
        @(posedge clk); #1;
        miss(32'h0040_3000, 0, "R11");

        // 4 KB entry
        fill(32'h0040_3000, 24'h012345, 0, 0, 1, 4'b1110);
        look(32'h0040_3ABC, 0, 1, 36'h012345ABC, 4'b1110, "R2");
        miss(32'h0040_4ABC, 0, "R2");
        // 4 MB and 2 MB entries
        fill(32'h8040_0000, 24'hABC400, 1, 1, 1, 4'b0001);
        look(32'h807F_1234, 0, 1, epa(24'hABC400, 1, 32'h807F_1234), 4'b0001, "R3");
        miss(32'h8080_0000, 0, "R3");
        miss(32'h803F_FFFF, 0, "R3");
        fill(32'hC020_0000, 24'h000600, 2, 0, 0, 4'b1000);
        look(32'hC03F_FFFF, 0, 1, epa(24'h000600, 2, 32'hC03F_FFFF), 4'b1000, "R3");
        miss(32'hC040_0000, 0, "R3");
        // dirty rule
        miss(32'hC020_0010, 1, "R4");
        look(32'h0040_3000, 1, 1, 36'h012345000, 4'b1110, "R4");
        // single-page invalidate
        inv(32'h0040_3FFF);
        miss(32'h0040_3000, 0, "R7");
        look(32'h8040_0000, 0, 1, epa(24'hABC400, 1, 32'h8040_0000), 4'b0001, "R7");
        look(32'hC020_0000, 0, 1, epa(24'h000600, 2, 32'hC020_0000), 4'b1000, "R7");
        // reloads
        reload(1);
        look(32'h8050_0000, 0, 1, epa(24'hABC400, 1, 32'h8050_0000), 4'b0001, "R6");
        miss(32'hC020_0000, 0, "R6");
        reload(0);
        miss(32'h8050_0000, 0, "R5");
        // same-cycle invalidate and refill
        put_fill(32'h1000_0000, 24'h000001, 0, 0, 1, 4'b1100);
        inv(32'h1000_0123);
        miss(32'h1000_0000, 0, "R8");
        put_fill(32'h2000_0000, 24'h000002, 0, 0, 1, 4'b1100);
        inv(32'h3000_0000);
        look(32'h2000_0044, 0, 1, 36'h000002044, 4'b1100, "R8");
        put_fill(32'h5000_0000, 24'h000005, 0, 1, 1, 4'b0010);
        reload(1);
        look(32'h5000_0008, 0, 1, 36'h000005008, 4'b0010, "R6");
        put_fill(32'h6000_0000, 24'h000006, 0, 0, 1, 4'b0010);
        reload(1);
        miss(32'h6000_0000, 0, "R6");
        put_fill(32'h6000_0000, 24'h000006, 0, 1, 1, 4'b0010);
        reload(0);
        miss(32'h6000_0000, 0, "R5");
        miss(32'h5000_0000, 0, "R5");
        // round-robin replacement
        for (int i = 0; i < 8; i++) fill(pg[i], 24'h000100 + 24'(i), 0, 0, 1, 4'b1100);
        for (int i = 0; i < 8; i++)
            look(pg[i], 0, 1, {24'h000100 + 24'(i), 12'h000}, 4'b1100, "R9");
        fill(pg[8], 24'h000108, 0, 0, 1, 4'b1100);
        miss(pg[0], 0, "R9");
        look(pg[1], 0, 1, 36'h000101000, 4'b1100, "R9");
        look(pg[8], 0, 1, 36'h000108000, 4'b1100, "R9");
        fill(pg[9], 24'h000109, 0, 0, 1, 4'b1100);
        miss(pg[1], 0, "R9");
        look(pg[2], 0, 1, 36'h000102000, 4'b1100, "R9");
        // in-place refill
        fill(pg[2], 24'h0002FF, 0, 0, 1, 4'b1100);
        look(pg[2], 0, 1, 36'h0002FF000, 4'b1100, "R10");
        look(pg[3], 0, 1, 36'h000103000, 4'b1100, "R10");
        look(pg[8], 0, 1, 36'h000108000, 4'b1100, "R10");
        look(pg[9], 0, 1, 36'h000109000, 4'b1100, "R10");
        fill(pg[10], 24'h00010A, 0, 0, 1, 4'b1100);
        miss(pg[2], 0, "R10");
        look(pg[3], 0, 1, 36'h000103000, 4'b1100, "R10");
        // empty slot preferred over pointer
        inv(pg[5]);
        fill(pg[11], 24'h00010B, 0, 0, 1, 4'b1100);
        look(pg[11], 0, 1, 36'h00010B000, 4'b1100, "R9");
        look(pg[3], 0, 1, 36'h000103000, 4'b1100, "R9");
        look(pg[4], 0, 1, 36'h000104000, 4'b1100, "R9");

        repeat (3) @(posedge clk);
        n_chk++;
        if (q_hit.size() != 0) begin
            n_bad++;
            $display("FAIL R1: pending answers act=%0d exp=0", q_hit.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule